// File: doc/BRIEF.md
# DRAM Parallel Test-Mode Engine

This block is a synthesizable behavioural model of the test-mode logic on the memory side of an asynchronous DRAM. It samples the row strobe, column strobe, write enable, multiplexed address and data input on a fast system clock. From the order in which those strobes move, it decides whether a cycle is a normal access, a refresh, or a request to enter a latched test mode. A small internal cell array stands in for the memory core.

In test mode, every data bit position stands for a group of eight cells. The eight cells differ only in the two lowest column bits and the top column bit, and those three bits are ignored. A test-mode write copies each input bit into all eight cells of its group. A test-mode read returns, for each bit, a 1 when all eight cells hold the same value and a 0 when any of them differs. This lets a tester check a larger array in fewer accesses. The extra delay that test-mode reads have on a real device is modelled as a parameter counted in clock cycles.

Top module: `dtm_test_model`

## Requirements
- R1: While reset is asserted and just after it is released, `test_active` is 0 and `dq_oe` is 0.
- R2: A cycle in which `col_strobe_n` and `wr_en_n` are both low at the sample before and at the sample where `row_strobe_n` falls, with `wr_en_n` still low one sample later, sets `test_active` to 1 after that later edge.
- R3: If `wr_en_n` has returned high at the sample after the row strobe falls (missing hold), test mode is not entered.
- R4: A refresh with the column strobe low before the row strobe falls and write enable high clears `test_active`.
- R5: A row cycle in which the column strobe never falls before the row strobe rises clears `test_active` at the rise.
- R6: In normal mode, a write stores `dq_in` at cell {row, column}. A read drives that cell on `dq_out` with `dq_oe` high exactly NORM_LAT edges after the edge that samples the column strobe falling, and `dq_oe` stays low before then.
- R7: In test mode, a read returns for bit b a 1 when bit b of all eight grouped cells is equal, and 0 otherwise. The group is the latched column with bit 0, bit 1 and bit COL_W-1 taking all eight values.
- R8: A test-mode read presents its result NORM_LAT+TEST_EXTRA edges after the column strobe falls.
- R9: A test-mode write stores `dq_in` into all eight cells of the group, as normal-mode reads show afterwards.
- R10: At the edge that samples the column strobe high again, `dq_oe` goes low.
- R11: A test-mode read result does not depend on column bits 0, 1 and COL_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_strobe_n | input | 1 | Row address strobe, active low |
| col_strobe_n | input | 1 | Column address strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| addr | input | max(ROW_W,COL_W) | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data |
| dq_out | output | DQ_W | Read data or per-bit compare result |
| dq_oe | output | 1 | Output drive enable |
| test_active | output | 1 | Latched test-mode flag |

## Verification
On every cycle, the assertions check the following: the test flag moves only after a refresh-type check cycle or a row-strobe rise, and entry always has write enable low. The output enable rises only from a pending read and drops once the column strobe rises. Driven data holds steady while the output stays enabled. Only the bench scenarios can show the values themselves: the compare result over grouped cells, the replication of a test write, the exact read latencies in each mode, and that the ignored column bits make no difference.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  localparam int unsigned GRP_N = 8;
  localparam int unsigned GRP_W = 3;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_e;
endpackage

// File: rtl/dtm_strobe_dec.sv
module dtm_strobe_dec
  import dtm_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 5,
  parameter int ADDR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_strobe_n,
  input  logic             col_strobe_n,
  input  logic             wr_en_n,
  input  logic [ADDR_W-1:0] addr,
  output acc_e             acc,
  output logic [ROW_W-1:0] acc_row,
  output logic [COL_W-1:0] acc_col,
  output logic             col_rise,
  output logic             test_flag
);
  // previous samples of the strobes
  logic ras_q, cas_q, we_q;
  logic row_open, row_open_d;
  logic cas_seen, cas_seen_d;
  logic cbr_chk, cbr_chk_d;
  logic we_ok, we_ok_d;
  logic test_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic ras_fall, ras_rise, cas_fall;

  assign ras_fall = ras_q & ~row_strobe_n;
  assign ras_rise = ~ras_q & row_strobe_n;
  assign cas_fall = cas_q & ~col_strobe_n;
  assign col_rise = ~cas_q & col_strobe_n;

  assign acc_row = row_q;
  assign acc_col = addr[COL_W-1:0];

  always_comb begin
    acc = ACC_NONE;
    if (row_open && cas_fall && !row_strobe_n)
      acc = wr_en_n ? ACC_RD : ACC_WR;
  end

  always_comb begin
    row_open_d = row_open;
    cas_seen_d = cas_seen;
    cbr_chk_d  = 1'b0;
    we_ok_d    = we_ok;
    test_d     = test_flag;
    row_d      = row_q;
    if (ras_fall) begin
      if (!col_strobe_n) begin
        cbr_chk_d = 1'b1;
        we_ok_d   = ~we_q & ~wr_en_n;
      end else begin
        row_open_d = 1'b1;
        cas_seen_d = 1'b0;
        row_d      = addr[ROW_W-1:0];
      end
    end
    if (cbr_chk)
      test_d = we_ok & ~wr_en_n;
    if (acc != ACC_NONE)
      cas_seen_d = 1'b1;
    if (ras_rise) begin
      row_open_d = 1'b0;
      if (row_open && !cas_seen)
        test_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q     <= 1'b1;
      cas_q     <= 1'b1;
      we_q      <= 1'b1;
      row_open  <= 1'b0;
      cas_seen  <= 1'b0;
      cbr_chk   <= 1'b0;
      we_ok     <= 1'b0;
      test_flag <= 1'b0;
      row_q     <= '0;
    end else begin
      ras_q     <= row_strobe_n;
      cas_q     <= col_strobe_n;
      we_q      <= wr_en_n;
      row_open  <= row_open_d;
      cas_seen  <= cas_seen_d;
      cbr_chk   <= cbr_chk_d;
      we_ok     <= we_ok_d;
      test_flag <= test_d;
      row_q     <= row_d;
    end
  end

  // R4 R5: the flag only moves after a refresh check cycle or a row-strobe rise
  a_r5_flag_moves_on_refresh_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(test_flag) |-> ($past(cbr_chk) || $past(ras_rise)));

  // R2: entry always saw write enable held low
  a_r2_entry_needs_we_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_flag) |-> $past(!wr_en_n));
endmodule

// File: rtl/dtm_cell_array.sv
module dtm_cell_array
  import dtm_pkg::*;
#(
  parameter int ROW_W = 3,
  parameter int COL_W = 5,
  parameter int DQ_W  = 4
) (
  input  logic             clk,
  input  acc_e             acc,
  input  logic [ROW_W-1:0] acc_row,
  input  logic [COL_W-1:0] acc_col,
  input  logic [DQ_W-1:0]  wr_data,
  input  logic             test_mode,
  output logic [DQ_W-1:0]  rd_word
);
  localparam int IDX_W = ROW_W + COL_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DQ_W-1:0]  mem [DEPTH];
  logic [IDX_W-1:0] grp_idx [GRP_N];
  logic [GRP_N-1:0] grp_bits [DQ_W];
  logic [IDX_W-1:0] flat_idx;

  assign flat_idx = {acc_row, acc_col};

  // the eight cells that share a data bit in test mode
  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    logic [COL_W-1:0] gcol;
    logic [GRP_W-1:0] gsel;
    assign gsel = GRP_W'(g);
    always_comb begin
      gcol          = acc_col;
      gcol[0]       = gsel[0];
      gcol[1]       = gsel[1];
      gcol[COL_W-1] = gsel[2];
    end
    assign grp_idx[g] = {acc_row, gcol};
    for (genvar b = 0; b < DQ_W; b++) begin : g_bit
      assign grp_bits[b][g] = mem[grp_idx[g]][b];
    end
  end

  always_ff @(posedge clk) begin
    if (acc == ACC_WR) begin
      if (test_mode) begin
        for (int g = 0; g < GRP_N; g++)
          mem[grp_idx[g]] <= wr_data;
      end else begin
        mem[flat_idx] <= wr_data;
      end
    end
  end

  always_comb begin
    if (test_mode) begin
      for (int b = 0; b < DQ_W; b++)
        rd_word[b] = (&grp_bits[b]) | ~(|grp_bits[b]);
    end else begin
      rd_word = mem[flat_idx];
    end
  end
endmodule

// File: rtl/dtm_read_pipe.sv
module dtm_read_pipe #(
  parameter int DQ_W       = 4,
  parameter int NORM_LAT   = 2,
  parameter int TEST_EXTRA = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic            test_mode,
  input  logic [DQ_W-1:0] rd_word,
  input  logic            col_rise,
  output logic [DQ_W-1:0] dq_out,
  output logic            dq_oe
);
  localparam int LAT_MAX = NORM_LAT + TEST_EXTRA;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);
  localparam logic [CNT_W-1:0] LD_NORM = CNT_W'(NORM_LAT - 1);
  localparam logic [CNT_W-1:0] LD_TEST = CNT_W'(LAT_MAX - 1);

  logic            pend, pend_d;
  logic [CNT_W-1:0] cnt, cnt_d;
  logic [DQ_W-1:0] hold, hold_d;
  logic [DQ_W-1:0] out_d;
  logic            oe_d;

  always_comb begin
    pend_d = pend;
    cnt_d  = cnt;
    hold_d = hold;
    out_d  = dq_out;
    oe_d   = dq_oe;
    if (col_rise) begin
      pend_d = 1'b0;
      oe_d   = 1'b0;
    end else if (launch) begin
      pend_d = 1'b1;
      cnt_d  = test_mode ? LD_TEST : LD_NORM;
      hold_d = rd_word;
      oe_d   = 1'b0;
    end else if (pend) begin
      if (cnt == '0) begin
        pend_d = 1'b0;
        oe_d   = 1'b1;
        out_d  = hold;
      end else begin
        cnt_d = cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      cnt    <= '0;
      hold   <= '0;
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end else begin
      pend   <= pend_d;
      cnt    <= cnt_d;
      hold   <= hold_d;
      dq_out <= out_d;
      dq_oe  <= oe_d;
    end
  end

  a_r10_oe_drops_after_cas_rise: assert property (@(posedge clk) disable iff (!rst_n)
    col_rise |=> !dq_oe);

  a_r6_oe_from_pending_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(pend));

  a_r6_data_steady_while_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_out));
endmodule

// File: rtl/dtm_test_model.sv
module dtm_test_model
  import dtm_pkg::*;
#(
  parameter int ROW_W      = 3,
  parameter int COL_W      = 5,
  parameter int DQ_W       = 4,
  parameter int NORM_LAT   = 2,
  parameter int TEST_EXTRA = 1
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     row_strobe_n,
  input  logic                                     col_strobe_n,
  input  logic                                     wr_en_n,
  input  logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] addr,
  input  logic [DQ_W-1:0]                          dq_in,
  output logic [DQ_W-1:0]                          dq_out,
  output logic                                     dq_oe,
  output logic                                     test_active
);
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  acc_e             acc;
  logic [ROW_W-1:0] acc_row;
  logic [COL_W-1:0] acc_col;
  logic             col_rise;
  logic [DQ_W-1:0]  rd_word;

  dtm_strobe_dec #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .ADDR_W(ADDR_W)
  ) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .row_strobe_n(row_strobe_n),
    .col_strobe_n(col_strobe_n),
    .wr_en_n     (wr_en_n),
    .addr        (addr),
    .acc         (acc),
    .acc_row     (acc_row),
    .acc_col     (acc_col),
    .col_rise    (col_rise),
    .test_flag   (test_active)
  );

  dtm_cell_array #(
    .ROW_W(ROW_W),
    .COL_W(COL_W),
    .DQ_W (DQ_W)
  ) u_array (
    .clk      (clk),
    .acc      (acc),
    .acc_row  (acc_row),
    .acc_col  (acc_col),
    .wr_data  (dq_in),
    .test_mode(test_active),
    .rd_word  (rd_word)
  );

  dtm_read_pipe #(
    .DQ_W      (DQ_W),
    .NORM_LAT  (NORM_LAT),
    .TEST_EXTRA(TEST_EXTRA)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (acc == ACC_RD),
    .test_mode(test_active),
    .rd_word  (rd_word),
    .col_rise (col_rise),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
  );

  a_r6_oe_needs_cas_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(!col_strobe_n));
endmodule

// File: tb/dtm_test_model_tb.sv
module dtm_test_model_tb;
  localparam int ROW_W = 3, COL_W = 5, DQ_W = 4;
  localparam int NLAT = 2, TEXTRA = 1;

  logic clk = 1'b0;
  logic rst_n;
  logic ras_n, cas_n, we_n;
  logic [4:0] addr;
  logic [3:0] dq_in;
  logic [3:0] dq_out;
  logic dq_oe, test_active;

  int total = 0, fails = 0;
  bit done = 0;
  logic [3:0] mdl [256];

  always #4 clk = ~clk;

  dtm_test_model u_dut (
    .clk(clk), .rst_n(rst_n), .row_strobe_n(ras_n), .col_strobe_n(cas_n),
    .wr_en_n(we_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .test_active(test_active)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] gcol(input logic [4:0] c, input int g);
    logic [4:0] r = c;
    r[0] = g[0]; r[1] = g[1]; r[4] = g[2];
    return r;
  endfunction

  function automatic logic [3:0] tm_expect(input logic [2:0] row, input logic [4:0] col);
    logic [3:0] r;
    for (int b = 0; b < 4; b++) begin
      logic all1 = 1'b1, all0 = 1'b1;
      for (int g = 0; g < 8; g++) begin
        if (mdl[{row, gcol(col, g)}][b]) all0 = 1'b0; else all1 = 1'b0;
      end
      r[b] = all1 | all0;
    end
    return r;
  endfunction

  task automatic do_write(input logic [2:0] row, input logic [4:0] col, input logic [3:0] d);
    @(negedge clk); ras_n = 0; addr = {2'b0, row};
    @(negedge clk); addr = col; we_n = 0; cas_n = 0; dq_in = d;
    @(negedge clk); cas_n = 1; we_n = 1;
    @(negedge clk); ras_n = 1;
    @(negedge clk);
  endtask

  task automatic do_read(input logic [2:0] row, input logic [4:0] col, input int lat,
                         input string req, output logic [3:0] d);
    @(negedge clk); ras_n = 0; addr = {2'b0, row};
    @(negedge clk); addr = col; cas_n = 0;
    @(negedge clk);
    repeat (lat - 1) @(negedge clk);
    chk({req, " oe low before latency"}, dq_oe, 0);
    @(negedge clk);
    chk({req, " oe high at latency"}, dq_oe, 1);
    d = dq_out;
    cas_n = 1;
    @(negedge clk);
    chk("R10 oe off after cas rise", dq_oe, 0);
    ras_n = 1;
    @(negedge clk);
  endtask

  task automatic do_cbr(input bit we_low, input bit we_hold);
    @(negedge clk); cas_n = 0; we_n = we_low ? 1'b0 : 1'b1;
    @(negedge clk); ras_n = 0;
    @(negedge clk); if (!we_hold) we_n = 1;
    @(negedge clk); ras_n = 1; cas_n = 1; we_n = 1;
    @(negedge clk);
  endtask

  task automatic do_ras_only(input logic [2:0] row);
    @(negedge clk); ras_n = 0; addr = {2'b0, row};
    @(negedge clk); ras_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [3:0] d, v;
    logic [2:0] row;
    logic [4:0] col;
    logic [2:0] grow [6];
    logic [4:0] gc0 [6];
    void'($urandom(32'h0D1A5EED));
    rst_n = 0; ras_n = 1; cas_n = 1; we_n = 1; addr = '0; dq_in = '0;
    for (int i = 0; i < 256; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 test flag in reset", test_active, 0);
    chk("R1 oe in reset", dq_oe, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 test flag after reset", test_active, 0);
    chk("R1 oe after reset", dq_oe, 0);

    // init all cells so later compares are deterministic
    for (int i = 0; i < 256; i++) begin
      d = 4'($urandom);
      do_write(3'(i >> 5), 5'(i), d);
      mdl[i] = d;
    end

    // R6 normal write and read at random addresses
    for (int i = 0; i < 16; i++) begin
      row = 3'($urandom); col = 5'($urandom); d = 4'($urandom);
      do_write(row, col, d); mdl[{row, col}] = d;
      do_read(row, col, NLAT, "R6", v);
      chk("R6 normal read data", v, d);
    end

    // R3 missing WE hold: no entry
    do_cbr(1, 0);
    chk("R3 no entry without we hold", test_active, 0);

    // groups with chosen agreement patterns
    for (int gi = 0; gi < 6; gi++) begin
      logic [3:0] eqmask, eqval;
      grow[gi] = 3'($urandom); gc0[gi] = 5'($urandom);
      eqmask = (gi == 0) ? 4'hF : (gi == 1) ? 4'h0 : 4'($urandom);
      eqval = 4'($urandom);
      for (int g = 0; g < 8; g++) begin
        d = 4'($urandom);
        d = (d & ~eqmask) | (eqval & eqmask);
        if (gi == 1) d = (g == 0) ? 4'h0 : (g == 7) ? 4'hF : d;
        do_write(grow[gi], gcol(gc0[gi], g), d);
        mdl[{grow[gi], gcol(gc0[gi], g)}] = d;
      end
    end

    do_cbr(1, 1);
    chk("R2 entry", test_active, 1);

    for (int gi = 0; gi < 6; gi++) begin
      col = gcol(gc0[gi], int'($urandom % 8));
      do_read(grow[gi], col, NLAT + TEXTRA, "R8", v);
      chk("R7 compare result", v, tm_expect(grow[gi], gc0[gi]));
      if (gi == 0) chk("R7 all equal gives ones", v, 4'hF);
      if (gi == 1) chk("R7 mismatch gives zeros", v, 4'h0);
      do_read(grow[gi], gcol(col, int'(~col[0]) & 7), NLAT + TEXTRA, "R11", d);
      chk("R11 ignored column bits", d, v);
    end

    // R9 test write replication
    row = 3'($urandom); col = 5'($urandom); d = 4'($urandom);
    do_write(row, col, d);
    for (int g = 0; g < 8; g++) mdl[{row, gcol(col, g)}] = d;
    do_read(row, col, NLAT + TEXTRA, "R8", v);
    chk("R9 test read after test write", v, 4'hF);
    chk("R2 still latched", test_active, 1);

    do_cbr(0, 0);
    chk("R4 plain refresh clears", test_active, 0);
    for (int g = 0; g < 8; g++) begin
      do_read(row, gcol(col, g), NLAT, "R6", v);
      chk("R9 replicated cell", v, d);
    end

    do_cbr(1, 1);
    chk("R2 re-entry", test_active, 1);
    do_ras_only(3'($urandom));
    chk("R5 ras-only refresh clears", test_active, 0);

    do_cbr(1, 1);
    chk("R2 entry again", test_active, 1);
    do_cbr(1, 0);
    chk("R3 failed hold acts as exit", test_active, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule